// File: doc/BRIEF.md
# ATM Cell Delineation Engine

This block takes a byte stream lifted from the payload of a transmission link and finds the 53-byte ATM cell boundaries in it. It uses the header error control (HEC) byte as the framing marker. A byte-wise search looks for the first 5-byte window whose last byte is a valid HEC for the four bytes before it. The engine then runs a cell-by-cell confirmation phase. After that it settles in a synchronised state, where each header is checked and the cell is passed on, repaired or dropped.

While synchronised, a two-mode header policy applies. In correction mode a single-bit header error is repaired. In detection mode every damaged header is rejected. Cells whose headers pass are emitted as 53 bytes, with a start-of-cell mark on the first byte and the repaired header in place. Two options can be switched on: payload de-scrambling, and dropping of idle cells. Two saturating-free wrap-around counters report how many cells were repaired and how many were thrown away.

The configuration inputs are expected to stay constant between resets.

Top module: `atm_cell_delin`

## Requirements
- R1: The HEC of a 4-byte header h is the remainder of h·x^8 divided by x^8+x^2+x+1 (header MSB first), XORed with 0x55. After reset, once four bytes have been received, every accepted input byte closes a 5-byte candidate window. The first window whose fifth byte equals the HEC of its first four bytes locks the cell boundary, and that byte is taken as the fifth byte of a cell.
- R2: After a lock, one header per cell is checked. A header that fails returns the engine to the search. When DELTA further headers in a row are correct (default 6), the engine becomes synchronised. The cells checked before that point are never emitted.
- R3: While synchronised, the engine returns to the byte-wise search when ALPHA headers in a row carry a nonzero syndrome (default 7). A repaired header counts as one of these. The ALPHA-th such cell is discarded.
- R4: In correction mode, a header with exactly one flipped bit among its 40 bits is repaired. The cell is emitted with the repaired five header bytes, `corr_count` increments, and the engine enters detection mode.
- R5: A header with two or more bit errors in correction mode is discarded. Any header error in detection mode also discards the cell. Each discard increments `disc_count` and leaves or puts the engine in detection mode. An error-free header returns the engine to correction mode.
- R6: Each emitted cell appears as 53 consecutive `out_valid` bytes in input order. `out_soc` is high on the first of them. Only cells whose header was checked while synchronised can be emitted. Output bytes trail the input by five accepted bytes plus one register stage.
- R7: With `cfg_idle_drop` high, a cell whose header (after any repair) is 0x00,0x00,0x00,0x01 is not emitted. With it low, such cells are emitted like any other.
- R8: With `cfg_descr_en` high, the 48 payload bytes are de-scrambled bit-serially, MSB first, as out = in XOR (input bit received 43 payload bits earlier). The de-scrambler advances only on payload bytes and is held while searching. Header bytes always pass unchanged.
- R9: After reset `in_sync`, `out_valid`, `corr_count` and `disc_count` are all 0, and each counter changes only by +1 on its own event.
- R10: `in_sync` is high exactly while the engine is in the synchronised state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_descr_en | input | 1 | Enable payload de-scrambling |
| cfg_idle_drop | input | 1 | Enable dropping of idle cells |
| in_valid | input | 1 | An input byte is present this cycle |
| in_byte | input | 8 | Input byte from the link payload |
| out_valid | output | 1 | An output cell byte is present |
| out_soc | output | 1 | Marks the first byte of an output cell |
| out_byte | output | 8 | Output cell byte |
| in_sync | output | 1 | Engine is in the synchronised state |
| corr_count | output | CNT_W | Number of cells with a repaired header |
| disc_count | output | CNT_W | Number of cells discarded while synchronised |

## Verification
The assertions assume that the two configuration inputs change only while reset is held. They also assume that `in_valid` may drop for any number of cycles without any effect on the cell position. The stimulus holds both options fixed for a whole run phase and switches them only across a reset. It inserts idle gaps at random between bytes. It only injects one-bit or two-bit header errors. It also re-draws any payload or header byte that would form an accidental valid HEC window away from a true cell boundary, so that the search can only lock on real boundaries.

// File: rtl/cd_pkg.sv
package cd_pkg;

  typedef enum logic [1:0] {
    ST_HUNT    = 2'd0,
    ST_PRESYNC = 2'd1,
    ST_SYNC    = 2'd2
  } cd_state_e;

  localparam int          CW_BITS   = 40;   // header plus check byte
  localparam int          SCR_LEN   = 43;   // self-synchronising span
  localparam logic [7:0]  HEC_COSET = 8'h55;
  localparam logic [31:0] IDLE_HDR  = 32'h0000_0001;

  // CRC-8, generator x^8+x^2+x+1, zero preset, MSB first
  function automatic logic [7:0] hec_calc(input logic [31:0] hdr);
    logic [7:0] c;
    logic       fb;
    c = 8'h00;
    for (int b = 31; b >= 0; b--) begin
      fb = c[7] ^ hdr[b];
      c  = {c[6:0], 1'b0};
      if (fb) c = c ^ 8'h07;
    end
    return c;
  endfunction

  // syndrome produced by a single flipped bit at codeword position i
  function automatic logic [7:0] unit_syn(input int i);
    if (i < 8) return 8'(1 << i);
    return hec_calc(32'(1) << (i - 8));
  endfunction

  // one byte through the x^43+1 de-scrambler: returns {next state, byte}
  function automatic logic [SCR_LEN+7:0] descr_step(input logic [SCR_LEN-1:0] st,
                                                    input logic [7:0] din);
    logic [SCR_LEN-1:0] s;
    logic [7:0]         o;
    s = st;
    for (int b = 7; b >= 0; b--) begin
      o[b] = din[b] ^ s[SCR_LEN-1];
      s    = {s[SCR_LEN-2:0], din[b]};
    end
    return {s, o};
  endfunction

endpackage

// File: rtl/cd_hec_check.sv
module cd_hec_check
  import cd_pkg::*;
(
  input  logic [CW_BITS-1:0] word_i,
  output logic               ok_o,
  output logic               single_o,
  output logic [CW_BITS-1:0] fixed_o
);
  logic [7:0]         syn;
  logic [CW_BITS-1:0] hit;

  assign syn = hec_calc(word_i[CW_BITS-1:8]) ^ HEC_COSET ^ word_i[7:0];

  generate
    for (genvar i = 0; i < CW_BITS; i++) begin : g_pos
      localparam logic [7:0] USYN = unit_syn(i);
      assign hit[i] = (syn == USYN);
    end
  endgenerate

  assign ok_o     = (syn == 8'h00);
  assign single_o = |hit;
  assign fixed_o  = word_i ^ hit;
endmodule

// File: rtl/cd_sync_fsm.sv
module cd_sync_fsm
  import cd_pkg::*;
#(
  parameter int ALPHA = 7,
  parameter int DELTA = 6
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      hunt_step_i,
  input  logic      at_check_i,
  input  logic      hec_ok_i,
  input  logic      single_i,
  output cd_state_e state_o,
  output logic      corr_mode_o,
  output logic      ev_lock_o,
  output logic      ev_accept_o,
  output logic      ev_correct_o,
  output logic      ev_discard_o,
  output logic      ev_lost_o
);
  localparam int RUN_MAX = (ALPHA > DELTA) ? ALPHA : DELTA;
  localparam int RUN_W   = $clog2(RUN_MAX + 1);

  cd_state_e        st_q, st_d;
  logic [RUN_W-1:0] run_q, run_d;
  logic             corr_q, corr_d;

  always_comb begin
    st_d         = st_q;
    run_d        = run_q;
    corr_d       = corr_q;
    ev_lock_o    = 1'b0;
    ev_accept_o  = 1'b0;
    ev_correct_o = 1'b0;
    ev_discard_o = 1'b0;
    ev_lost_o    = 1'b0;
    unique case (st_q)
      ST_HUNT: begin
        if (hunt_step_i && hec_ok_i) begin
          st_d      = ST_PRESYNC;
          run_d     = '0;
          ev_lock_o = 1'b1;
        end
      end
      ST_PRESYNC: begin
        if (at_check_i) begin
          if (!hec_ok_i) begin
            st_d      = ST_HUNT;
            ev_lost_o = 1'b1;
          end else if (run_q == RUN_W'(DELTA - 1)) begin
            st_d   = ST_SYNC;
            run_d  = '0;
            corr_d = 1'b1;
          end else begin
            run_d = run_q + 1'b1;
          end
        end
      end
      ST_SYNC: begin
        if (at_check_i) begin
          if (hec_ok_i) begin
            ev_accept_o = 1'b1;
            corr_d      = 1'b1;
            run_d       = '0;
          end else if (run_q == RUN_W'(ALPHA - 1)) begin
            st_d         = ST_HUNT;
            ev_discard_o = 1'b1;
            ev_lost_o    = 1'b1;
          end else begin
            run_d  = run_q + 1'b1;
            corr_d = 1'b0;
            if (corr_q && single_i) begin
              ev_accept_o  = 1'b1;
              ev_correct_o = 1'b1;
            end else begin
              ev_discard_o = 1'b1;
            end
          end
        end
      end
      default: st_d = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_HUNT;
      run_q  <= '0;
      corr_q <= 1'b1;
    end else begin
      st_q   <= st_d;
      run_q  <= run_d;
      corr_q <= corr_d;
    end
  end

  assign state_o     = st_q;
  assign corr_mode_o = corr_q;
endmodule

// File: rtl/cd_descrambler.sv
module cd_descrambler
  import cd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adv_i,
  input  logic [7:0] din_i,
  output logic [7:0] dout_o
);
  logic [SCR_LEN-1:0] st_q;
  logic [SCR_LEN+7:0] step;

  assign step   = descr_step(st_q, din_i);
  assign dout_o = step[7:0];

  always_ff @(posedge clk) begin
    if (!rst_n)     st_q <= '0;
    else if (adv_i) st_q <= step[SCR_LEN+7:8];
  end
endmodule

// File: rtl/atm_cell_delin.sv
module atm_cell_delin
  import cd_pkg::*;
#(
  parameter int ALPHA = 7,
  parameter int DELTA = 6,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_descr_en,
  input  logic             cfg_idle_drop,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  output logic             out_valid,
  output logic             out_soc,
  output logic [7:0]       out_byte,
  output logic             in_sync,
  output logic [CNT_W-1:0] corr_count,
  output logic [CNT_W-1:0] disc_count
);
  localparam int CELL_LEN = 53;
  localparam int HDR_LEN  = CW_BITS / 8;
  localparam int POS_W    = $clog2(CELL_LEN);
  localparam int FILL_W   = $clog2(HDR_LEN);

  // named internal events, observed by the checker
  cd_state_e          state;
  logic               corr_mode;
  logic               ev_lock, ev_accept, ev_correct, ev_discard, ev_lost;
  logic               at_check, hunt_step, hec_ok, single_err;

  logic [CW_BITS-1:0] win_q;       // last five accepted bytes
  logic [CW_BITS-1:0] cand;        // window closed by the current byte
  logic [CW_BITS-1:0] fixed;
  logic [FILL_W-1:0]  fill_q;
  logic [POS_W-1:0]   pos_q;       // cell position of the current byte
  logic [CW_BITS-1:0] hdr_q;
  logic               emit_q;
  logic               hdr_out, pay_out;
  logic [2:0]         hsel;
  logic [7:0]         oldest, hdr_byte, descr_byte;
  logic               is_idle;

  assign cand      = {win_q[CW_BITS-9:0], in_byte};
  assign oldest    = win_q[CW_BITS-1 -: 8];
  assign hunt_step = in_valid && (fill_q == FILL_W'(HDR_LEN - 1));
  assign at_check  = in_valid && (state != ST_HUNT) && (pos_q == POS_W'(HDR_LEN - 1));
  assign hdr_out   = (pos_q >= POS_W'(HDR_LEN)) && (pos_q < POS_W'(2 * HDR_LEN));
  assign pay_out   = !hdr_out;
  assign hsel      = 3'(pos_q - POS_W'(HDR_LEN));
  assign is_idle   = (fixed[CW_BITS-1:8] == IDLE_HDR);

  cd_hec_check u_hec (
    .word_i  (cand),
    .ok_o    (hec_ok),
    .single_o(single_err),
    .fixed_o (fixed)
  );

  cd_sync_fsm #(.ALPHA(ALPHA), .DELTA(DELTA)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .hunt_step_i (hunt_step),
    .at_check_i  (at_check),
    .hec_ok_i    (hec_ok),
    .single_i    (single_err),
    .state_o     (state),
    .corr_mode_o (corr_mode),
    .ev_lock_o   (ev_lock),
    .ev_accept_o (ev_accept),
    .ev_correct_o(ev_correct),
    .ev_discard_o(ev_discard),
    .ev_lost_o   (ev_lost)
  );

  cd_descrambler u_descr (
    .clk   (clk),
    .rst_n (rst_n),
    .adv_i (in_valid && (state != ST_HUNT) && pay_out),
    .din_i (oldest),
    .dout_o(descr_byte)
  );

  always_comb begin
    unique case (hsel)
      3'd0:    hdr_byte = hdr_q[39:32];
      3'd1:    hdr_byte = hdr_q[31:24];
      3'd2:    hdr_byte = hdr_q[23:16];
      3'd3:    hdr_byte = hdr_q[15:8];
      default: hdr_byte = hdr_q[7:0];
    endcase
  end

  // byte window, fill level and cell position
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_q  <= '0;
      fill_q <= '0;
      pos_q  <= '0;
    end else if (in_valid) begin
      win_q <= cand;
      if (fill_q != FILL_W'(HDR_LEN - 1)) fill_q <= fill_q + 1'b1;
      if (state == ST_HUNT)
        pos_q <= ev_lock ? POS_W'(HDR_LEN) : '0;
      else
        pos_q <= (pos_q == POS_W'(CELL_LEN - 1)) ? '0 : pos_q + 1'b1;
    end
  end

  // per-cell emit decision and latched header
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      emit_q <= 1'b0;
      hdr_q  <= '0;
    end else if (at_check) begin
      emit_q <= ev_accept && !(is_idle && cfg_idle_drop);
      hdr_q  <= fixed;
    end
  end

  // output register stage
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_soc   <= 1'b0;
      out_byte  <= '0;
    end else begin
      out_valid <= in_valid && emit_q;
      out_soc   <= in_valid && emit_q && (pos_q == POS_W'(HDR_LEN));
      if (in_valid)
        out_byte <= hdr_out ? hdr_byte : (cfg_descr_en ? descr_byte : oldest);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      corr_count <= '0;
      disc_count <= '0;
    end else begin
      if (ev_correct) corr_count <= corr_count + 1'b1;
      if (ev_discard) disc_count <= disc_count + 1'b1;
    end
  end

  assign in_sync = (state == ST_SYNC);
endmodule

// File: rtl/atm_cell_delin_checker.sv
module atm_cell_delin_checker
  import cd_pkg::*;
#(
  parameter int ALPHA = 7,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             out_valid,
  input logic             out_soc,
  input logic             in_sync,
  input cd_state_e        state,
  input logic             corr_mode,
  input logic             at_check,
  input logic             hec_ok,
  input logic             ev_correct,
  input logic             ev_discard,
  input logic [CNT_W-1:0] corr_count,
  input logic [CNT_W-1:0] disc_count
);
  localparam int BR_W = $clog2(ALPHA + 1);
  logic [BR_W-1:0] bad_run;

  always_ff @(posedge clk) begin
    if (!rst_n || !in_sync) bad_run <= '0;
    else if (at_check)      bad_run <= hec_ok ? '0 : bad_run + 1'b1;
  end

  assert_out_needs_sync_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_sync));

  assert_soc_in_cell_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_soc |-> out_valid);

  assert_no_hunt_to_sync_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HUNT) |=> !in_sync);

  assert_alpha_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_sync |-> (bad_run < BR_W'(ALPHA)));

  assert_fix_in_corr_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_correct |-> corr_mode);

  assert_fix_then_detect_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_correct |=> !corr_mode);

  assert_fix_or_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_correct, ev_discard}));

  assert_disc_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_discard |=> disc_count == CNT_W'($past(disc_count) + 1'b1));

  assert_corr_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_correct |=> corr_count == CNT_W'($past(corr_count) + 1'b1));

  assert_disc_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_discard |=> $stable(disc_count));

  assert_corr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_correct |=> $stable(corr_count));
endmodule

bind atm_cell_delin atm_cell_delin_checker #(.ALPHA(ALPHA), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .out_valid (out_valid),
  .out_soc   (out_soc),
  .in_sync   (in_sync),
  .state     (state),
  .corr_mode (corr_mode),
  .at_check  (at_check),
  .hec_ok    (hec_ok),
  .ev_correct(ev_correct),
  .ev_discard(ev_discard),
  .corr_count(corr_count),
  .disc_count(disc_count)
);

// File: tb/atm_cell_delin_tb_top.sv
module atm_cell_delin_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ALPHA = 7;
  localparam int DELTA = 6;
  localparam int CNT_W = 16;
  localparam int CELL = 53;
  localparam int MAXC = 400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_descr_en = 1'b0, cfg_idle_drop = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic out_valid, out_soc, in_sync;
  logic [7:0] out_byte;
  logic [CNT_W-1:0] corr_count, disc_count;

  always #(CLK_PERIOD/2) clk = ~clk;

  atm_cell_delin #(.ALPHA(ALPHA), .DELTA(DELTA), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_descr_en(cfg_descr_en), .cfg_idle_drop(cfg_idle_drop),
    .in_valid(in_valid), .in_byte(in_byte), .out_valid(out_valid), .out_soc(out_soc),
    .out_byte(out_byte), .in_sync(in_sync), .corr_count(corr_count), .disc_count(disc_count)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // bench state
  logic [31:0] h4;
  int          sent;
  logic [42:0] scr;
  int          m_state, m_run, m_cor, m_disc;
  bit          m_corr;
  logic [7:0]  exp_mem [0:MAXC*CELL-1];
  int          exp_n, rx_n, ridx;
  logic [7:0]  rxb [0:CELL-1];
  logic [7:0]  cur [0:CELL-1];

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // expected HEC by polynomial long division, coset added
  function automatic logic [7:0] hec_b(input logic [31:0] h);
    logic [39:0] r;
    r = {h, 8'h00};
    for (int b = 39; b >= 8; b--)
      if (r[b]) r = r ^ (40'h107 << (b - 8));
    return r[7:0] ^ 8'h55;
  endfunction

  function automatic bit win_ok(input logic [39:0] w);
    return hec_b(w[39:8]) == w[7:0];
  endfunction

  function automatic logic [50:0] scramble(input logic [42:0] st, input logic [7:0] p);
    logic [7:0] s;
    for (int b = 7; b >= 0; b--) begin
      s[b] = p[b] ^ st[42];
      st   = {st[41:0], s[b]};
    end
    return {st, s};
  endfunction

  task automatic feed(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_byte  = b;
    h4       = {h4[23:0], b};
    sent++;
    if ($urandom % 4 == 0) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // reference decision for one cell; returns 1 if the cell is emitted
  function automatic bit model(input int nb, input bit idle);
    bit em = 1'b0;
    case (m_state)
      0: if (nb == 0) begin m_state = 1; m_run = 0; end
      1: if (nb == 0) begin
           m_run++;
           if (m_run == DELTA) begin m_state = 2; m_run = 0; m_corr = 1'b1; end
         end else m_state = 0;
      default: if (nb == 0) begin
           em = 1'b1; m_corr = 1'b1; m_run = 0;
         end else begin
           m_run++;
           if (m_run == ALPHA) begin m_state = 0; m_disc++; end
           else if (m_corr && nb == 1) begin m_cor++; em = 1'b1; m_corr = 1'b0; end
           else begin m_disc++; m_corr = 1'b0; end
         end
    endcase
    if (idle && cfg_idle_drop) em = 1'b0;
    return em;
  endfunction

  task automatic gen_cell(input int nb, input bit idle, input string tag);
    logic [31:0] hdr;
    logic [39:0] cw, bad, msk;
    logic [71:0] seq;
    logic [50:0] st;
    logic [7:0]  p;
    logic [42:0] sv;
    bit clean, em;
    int p1, p2;
    do begin
      hdr = idle ? 32'h1 : $urandom;
      if (!idle && hdr == 32'h1) hdr = 32'h2;
      cw  = {hdr, hec_b(hdr)};
      msk = '0;
      p1  = $urandom % 40;
      p2  = (p1 + 1 + ($urandom % 39)) % 40;
      if (nb >= 1) msk[p1] = 1'b1;
      if (nb >= 2) msk[p2] = 1'b1;
      bad = cw ^ msk;
      seq = {h4, bad};
      clean = 1'b1;
      for (int j = 0; j < 4; j++)
        if (sent + j + 1 >= 5 && win_ok(seq[71-8*j -: 40])) clean = 1'b0;
    end while (!clean);
    for (int k = 0; k < 5; k++) begin
      cur[k] = cw[39-8*k -: 8];
      feed(bad[39-8*k -: 8]);
    end
    for (int k = 5; k < CELL; k++) begin
      sv = scr;
      do begin
        scr = sv;
        p   = $urandom;
        if (cfg_descr_en) begin
          st  = scramble(scr, p);
          scr = st[50:8];
        end else st = {scr, p};
      end while (win_ok({h4, st[7:0]}));
      cur[k] = p;
      feed(st[7:0]);
    end
    em = model(nb, idle);
    if (em) begin
      for (int k = 0; k < CELL; k++) exp_mem[exp_n*CELL + k] = cur[k];
      exp_n++;
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk(in_sync == (m_state == 2), tag, "in_sync after cell", int'(in_sync), int'(m_state == 2));
  endtask

  // output monitor
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (out_soc) ridx = 0;
      if (ridx < CELL) rxb[ridx] = out_byte;
      ridx++;
      if (ridx == CELL) begin
        if (rx_n >= exp_n) chk(1'b0, "R6", "unexpected cell index", rx_n, exp_n);
        else begin
          int bad_k = -1;
          for (int k = CELL-1; k >= 0; k--)
            if (rxb[k] !== exp_mem[rx_n*CELL + k]) bad_k = k;
          if (bad_k < 0) chk(1'b1, cfg_descr_en ? "R8" : "R6", "cell", 0, 0);
          else chk(1'b0, (bad_k >= 5 && cfg_descr_en) ? "R8" : (bad_k < 5 ? "R4" : "R6"),
                   $sformatf("cell %0d byte %0d", rx_n, bad_k),
                   int'(rxb[bad_k]), int'(exp_mem[rx_n*CELL + bad_k]));
        end
        rx_n++;
      end
    end
  end

  task automatic run_phase(input bit descr, input bit drop);
    int r;
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0;
    cfg_descr_en = descr; cfg_idle_drop = drop;
    h4 = '0; sent = 0; scr = '0;
    m_state = 0; m_run = 0; m_cor = 0; m_disc = 0; m_corr = 1'b1;
    exp_n = 0; rx_n = 0; ridx = CELL + 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_sync == 1'b0, "R9", "reset in_sync", int'(in_sync), 0);
    chk(out_valid == 1'b0, "R9", "reset out_valid", int'(out_valid), 0);
    chk(corr_count == 0, "R9", "reset corr_count", int'(corr_count), 0);
    chk(disc_count == 0, "R9", "reset disc_count", int'(disc_count), 0);
    // directed part
    gen_cell(0, 0, "R1");
    gen_cell(0, 0, "R2");
    gen_cell(0, 0, "R2");
    gen_cell(2, 0, "R2");
    for (int i = 0; i < DELTA + 1; i++) gen_cell(0, 0, "R2");
    gen_cell(0, 0, "R6");
    gen_cell(1, 0, "R4");
    gen_cell(1, 0, "R5");
    gen_cell(0, 0, "R5");
    gen_cell(2, 0, "R5");
    gen_cell(0, 0, "R5");
    gen_cell(0, 1, "R7");
    gen_cell(1, 1, "R7");
    gen_cell(0, 0, "R7");
    for (int i = 0; i < ALPHA; i++) gen_cell(1 + (i % 2), 0, "R3");
    gen_cell(1, 0, "R1");
    // random part
    for (int i = 0; i < 250; i++) begin
      r = $urandom % 100;
      if (r < 84)      gen_cell(0, 0, "R10");
      else if (r < 91) gen_cell(1, 0, "R10");
      else if (r < 96) gen_cell(2, 0, "R10");
      else             gen_cell($urandom % 2, 1, "R10");
    end
    chk(corr_count == CNT_W'(m_cor), "R4", "corr_count", int'(corr_count), m_cor);
    chk(disc_count == CNT_W'(m_disc), "R5", "disc_count", int'(disc_count), m_disc);
    // flush the tail of the last cell
    for (int k = 0; k < 5; k++) feed(8'hA5 ^ 8'(k));
    @(negedge clk); in_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(rx_n == exp_n, "R7", "emitted cell total", rx_n, exp_n);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    run_phase(1'b0, 1'b1);
    run_phase(1'b1, 1'b0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule